// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block is a 16-bit up-counter with two 16-bit data registers (A and B), a configuration byte and a run byte. A small 8-bit CPU accesses them over a byte-wide bus. The configuration byte selects one of four operating modes:

- plain timer, externally triggered timer or event counter;
- window (gated) counting;
- pulse width capture;
- programmable pulse output through a toggling flip-flop.

The source clock is either one of three prescaler tick inputs or an edge of the external pin. Before any logic uses the pin, it passes through a two-flop synchronizer and an edge detector.

A 16-bit data register is loaded by writing its low byte and then its high byte. The new value takes effect only at the next source tick after the high-byte write. The run byte holds the start field and the auto-capture enable. The start field values are:

- 00: stop and clear the counter;
- 01: start on command;
- 10: start on a rising pin edge;
- 11: start on a falling pin edge.

A match with register A raises a one-cycle `irq` and clears the counter. In pulse output mode, matches with A and with B each toggle `pulse_out`.

The control state machine has four states:

- `S_IDLE`: counter held at zero.
- `S_WAIT`: waiting for the trigger edge.
- `S_RUN`: counting.
- `S_DONE`: a one-shot pulse has ended.

Its transitions are:

- Any state goes to `S_IDLE` while the start field is 00.
- `S_IDLE` goes to `S_RUN` on a command start, in event mode, or in window mode. Otherwise it goes to `S_WAIT`.
- `S_WAIT` goes to `S_RUN` on the trigger edge, which clears the counter.
- `S_RUN` goes to `S_WAIT` in two cases: on the opposite edge when trigger-stop is set (timer with a pin start), or after a single-edge capture.
- `S_RUN` goes to `S_DONE` at the A match of a one-shot pulse.
- `S_DONE` holds until the start field is set back to 00.

Top module: `tmr16_top`

## Requirements
- R1: After reset, registers A and B read 0xFFFF, the count reads 0, the configuration byte reads 0x00 and `pulse_out` is 0. The bus addresses are: 0/1 A low/high, 2/3 B low/high, 4 configuration, 5 run, 6/7 count low/high.
- R2: A data register changes its active value only at the first source tick after its high byte (odd address) is written. A low-byte write alone leaves the value read back unchanged.
- R3: The run byte bits [1:0] form the start field. Writing 00 returns the counter to zero, and value 01 starts counting at once in timer mode.
- R4: The configuration byte layout is: bits [1:0] mode (0 timer, 1 window, 2 capture, 3 pulse), bits [3:2] clock select (0..2 tap inputs, 3 pin), bit 4 trigger-stop, bit 5 one-shot, bit 6 single-edge capture, bit 7 flip-flop preset. In timer mode, a source tick with the count equal to A clears the count and raises `irq` for one cycle.
- R5: A configuration write while the start field is non-zero is ignored: neither the byte read back nor `pulse_out` changes.
- R6: An accepted configuration write loads `pulse_out` with bit 7.
- R7: In pulse mode, a tick with the count equal to B toggles `pulse_out`. A tick with the count equal to A toggles it and clears the count, and generation continues.
- R8: With one-shot set, the count stays at 0 after the first A match and `pulse_out` no longer changes.
- R9: In timer mode with the pin as clock (event counting), start 10 counts rising pin edges and start 11 counts falling pin edges.
- R10: In window mode, ticks are counted only while the synchronized pin is high (start 10) or low (start 11).
- R11: In timer mode with a tap clock and start 10, counting begins at the rising pin edge from zero. With trigger-stop set, the falling edge halts counting and the count holds.
- R12: In capture mode, the count is stored into B at the capture edge, the count clears and `irq` pulses. Single-edge mode captures at the edge opposite to the start edge and then waits for the next start edge. Double-edge mode captures at every edge.
- R13: With run bit 2 (auto-capture) set in timer or window mode, every counted tick copies the count held before that tick into B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_addr | input | 3 | Register address for writes and reads |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for `bus_addr` |
| tap_tick | input | 3 | Single-cycle prescaler tick pulses |
| ext_pin | input | 1 | Asynchronous external pin |
| irq | output | 1 | One-cycle match or capture pulse |
| pulse_out | output | 1 | Output flip-flop |

## Verification
The assertions assume that tap ticks are single-cycle pulses and that the pin stays at each level for several clocks, so the synchronizer delivers clean edges. They also assume the start field is returned to 00 before the configuration is changed. The stimulus drives ticks as isolated one-cycle pulses with idle cycles between them. It holds every pin level for five clocks, and it writes the configuration while running only for the deliberate lock check. Bus reads are made only while no tick, edge or write is pending, so every read value is steady.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN, S_DONE} tstate_e;

    localparam logic [1:0] MD_TIMER  = 2'd0;
    localparam logic [1:0] MD_WINDOW = 2'd1;
    localparam logic [1:0] MD_CAPT   = 2'd2;
    localparam logic [1:0] MD_PULSE  = 2'd3;

    localparam logic [1:0] ST_STOP = 2'd0;
    localparam logic [1:0] ST_CMD  = 2'd1;
    localparam logic [1:0] ST_RISE = 2'd2;
    localparam logic [1:0] ST_FALL = 2'd3;

    localparam logic [1:0] CK_PIN = 2'd3;

    typedef struct packed {
        logic       ff_preset;
        logic       cap_single;
        logic       oneshot;
        logic       trig_stop;
        logic [1:0] clksel;
        logic [1:0] mode;
    } cfg_t;
endpackage

// File: rtl/tmr16_pinsync.sv
module tmr16_pinsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], pin};
    end

    assign lvl  = sh[STAGES-1];
    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/tmr16_dreg.sv
module tmr16_dreg #(
    parameter int W = 16,
    localparam int HB = W / 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [HB-1:0] wdata,
    input  logic         tick,
    input  logic         cap_en,
    input  logic [W-1:0] cap_val,
    output logic [W-1:0] act
);
    logic [W-1:0] stage;
    logic         pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage <= '1;
            act   <= '1;
            pend  <= 1'b0;
        end else begin
            if (cap_en) begin
                act <= cap_val;
            end else if (tick && pend) begin
                act  <= stage;
                pend <= 1'b0;
            end
            if (wr_lo) stage[HB-1:0] <= wdata;
            if (wr_hi) begin
                stage[W-1:HB] <= wdata;
                pend          <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
    import tmr16_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int BW         = CNT_W / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [2:0]    bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic [2:0]    tap_tick,
    input  logic          ext_pin,
    output logic          irq,
    output logic          pulse_out
);
    cfg_t             cfg_q;
    logic [1:0]       start_q;
    logic             autocap_q;
    tstate_e          st, st_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] dact [2];

    logic cfg_ok, pin_lvl, pin_rise, pin_fall;
    logic trig_edge, opp_edge, src_tick, gate_ok, cnt_tick;
    logic is_event, is_window, immediate, match_a, match_b, cap_evt, auto_cap;
    logic [3:0] src_vec;

    assign cfg_ok = bus_wr && bus_addr == 3'd4 && start_q == ST_STOP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            start_q   <= ST_STOP;
            autocap_q <= 1'b0;
        end else begin
            if (cfg_ok) cfg_q <= cfg_t'(bus_wdata);
            if (bus_wr && bus_addr == 3'd5) begin
                start_q   <= bus_wdata[1:0];
                autocap_q <= bus_wdata[2];
            end
        end
    end

    tmr16_pinsync #(.STAGES(SYNC_STAGES)) u_pin (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin),
        .lvl(pin_lvl), .rise(pin_rise), .fall(pin_fall)
    );

    assign trig_edge = (start_q == ST_FALL) ? pin_fall : pin_rise;
    assign opp_edge  = (start_q == ST_FALL) ? pin_rise : pin_fall;
    assign src_vec   = {trig_edge, tap_tick};
    assign src_tick  = src_vec[cfg_q.clksel];
    assign is_event  = cfg_q.mode == MD_TIMER && cfg_q.clksel == CK_PIN;
    assign is_window = cfg_q.mode == MD_WINDOW;
    assign gate_ok   = !is_window || ((start_q == ST_FALL) ? !pin_lvl : pin_lvl);
    assign cnt_tick  = src_tick && gate_ok && st == S_RUN;
    assign immediate = (start_q == ST_CMD && cfg_q.mode != MD_CAPT) || is_event || is_window;
    assign match_a   = cnt == dact[0];
    assign match_b   = cnt == dact[1];
    assign cap_evt   = st == S_RUN && cfg_q.mode == MD_CAPT &&
                       (cfg_q.cap_single ? opp_edge : (pin_rise | pin_fall));
    assign auto_cap  = autocap_q && cnt_tick &&
                       (cfg_q.mode == MD_TIMER || cfg_q.mode == MD_WINDOW);

    for (genvar i = 0; i < 2; i++) begin : g_dreg
        tmr16_dreg #(.W(CNT_W)) u_dreg (
            .clk(clk), .rst_n(rst_n),
            .wr_lo(bus_wr && bus_addr == 3'(2 * i)),
            .wr_hi(bus_wr && bus_addr == 3'(2 * i + 1)),
            .wdata(bus_wdata), .tick(src_tick),
            .cap_en((i == 1) ? (cap_evt | auto_cap) : 1'b0),
            .cap_val(cnt), .act(dact[i])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (start_q == ST_STOP) begin
            st_nx = S_IDLE;
        end else begin
            unique case (st)
                S_IDLE: st_nx = immediate ? S_RUN : S_WAIT;
                S_WAIT: if (trig_edge) st_nx = S_RUN;
                S_RUN: begin
                    if (cfg_q.mode == MD_TIMER && !is_event && cfg_q.trig_stop &&
                        start_q != ST_CMD && opp_edge)
                        st_nx = S_WAIT;
                    else if (cfg_q.mode == MD_CAPT && cfg_q.cap_single && opp_edge)
                        st_nx = S_WAIT;
                    else if (cfg_q.mode == MD_PULSE && cfg_q.oneshot && cnt_tick && match_a)
                        st_nx = S_DONE;
                end
                S_DONE: st_nx = S_DONE;
            endcase
        end
    end

    // counter, flip-flop and interrupt outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            irq       <= 1'b0;
            pulse_out <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (st == S_IDLE || (st == S_WAIT && trig_edge)) begin
                cnt <= '0;
            end else if (cap_evt) begin
                cnt <= '0;
                irq <= 1'b1;
            end else if (cnt_tick) begin
                if (match_a && cfg_q.mode != MD_CAPT) begin
                    cnt <= '0;
                    irq <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                if (cfg_q.mode == MD_PULSE) pulse_out <= pulse_out ^ match_a ^ match_b;
            end
            if (cfg_ok) pulse_out <= bus_wdata[7];
        end
    end

    always_comb begin
        unique case (bus_addr)
            3'd0: bus_rdata = dact[0][BW-1:0];
            3'd1: bus_rdata = dact[0][CNT_W-1:BW];
            3'd2: bus_rdata = dact[1][BW-1:0];
            3'd3: bus_rdata = dact[1][CNT_W-1:BW];
            3'd4: bus_rdata = cfg_q;
            3'd5: bus_rdata = BW'({autocap_q, start_q});
            3'd6: bus_rdata = cnt[BW-1:0];
            default: bus_rdata = cnt[CNT_W-1:BW];
        endcase
    end
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input tstate_e          st,
    input logic [1:0]       start_q,
    input cfg_t             cfg_q,
    input logic             cfg_ok,
    input logic             src_tick,
    input logic [CNT_W-1:0] a_act,
    input logic [CNT_W-1:0] cnt,
    input logic             pulse_out
);
    // R3: idle state forces the count to zero one cycle later
    p_idle_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_IDLE |=> cnt == '0);

    // R2: the active A value moves only on a source tick
    p_a_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !src_tick |=> $stable(a_act));

    // R5: configuration is frozen while the start field is non-zero
    p_cfg_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_q != 2'd0 |=> $stable(cfg_q));

    // R7: the output flip-flop moves only while running or on a preset write
    p_ff_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_RUN && !cfg_ok) |=> $stable(pulse_out));

    // R8: the finished one-shot state is held until stopped
    p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DONE && start_q != 2'd0) |=> st == S_DONE);
endmodule

bind tmr16_top tmr16_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .start_q(start_q), .cfg_q(cfg_q),
    .cfg_ok(cfg_ok), .src_tick(src_tick), .a_act(dact[0]), .cnt(cnt),
    .pulse_out(pulse_out)
);

// File: tb/sim_tmr16_top.sv
module sim_tmr16_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] tap_tick = '0;
    logic       ext_pin = 1'b0;
    logic       irq, pulse_out;

    int total = 0, fails = 0, irq_seen = 0;
    bit finished = 0;

    typedef struct {int kind; logic [15:0] exp; string tag;} item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    tmr16_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tap_tick(tap_tick),
        .ext_pin(ext_pin), .irq(irq), .pulse_out(pulse_out)
    );

    always @(negedge clk) if (rst_n && irq) irq_seen++;

    // monitor: compares queued expectations after each rising edge
    initial forever begin
        @(posedge clk);
        #2;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = {8'h00, bus_rdata};
                1:       act = {15'd0, pulse_out};
                default: act = 16'(irq_seen);
            endcase
            total++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic expect_item(input int kind, input logic [2:0] a,
                               input logic [15:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        sb_q.push_back('{kind, e, tag});
        @(posedge clk); #3;
    endtask

    task automatic expect_word(input logic [2:0] a, input logic [15:0] e, input string tag);
        expect_item(0, a, {8'h00, e[7:0]}, tag);
        expect_item(0, a + 3'd1, {8'h00, e[15:8]}, tag);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tap_tick[1] = 1'b1;
            @(negedge clk); tap_tick[1] = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic pin_to(input logic v);
        @(negedge clk); ext_pin = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic pin_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pin_to(1'b1); pin_to(1'b0);
        end
    endtask

    task automatic set_ab(input logic [15:0] a, input logic [15:0] b);
        wr(3'd0, a[7:0]); wr(3'd1, a[15:8]);
        wr(3'd2, b[7:0]); wr(3'd3, b[15:8]);
        ticks(1);
    endtask

    task automatic run(input logic [7:0] v);
        wr(3'd5, v);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int irq0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_word(3'd0, 16'hFFFF, "R1 A reset");
        expect_word(3'd2, 16'hFFFF, "R1 B reset");
        expect_word(3'd6, 16'h0000, "R1 count reset");
        expect_item(0, 3'd4, 16'h0000, "R1 cfg reset");
        expect_item(1, 3'd0, 16'h0000, "R1 pulse_out reset");

        // R2 double buffer, pin as source clock
        wr(3'd4, 8'h0C);
        wr(3'd0, 8'h34);
        pin_pulses(1);
        expect_word(3'd0, 16'hFFFF, "R2 low byte only");
        wr(3'd1, 8'h12);
        expect_word(3'd0, 16'hFFFF, "R2 before tick");
        pin_pulses(1);
        expect_word(3'd0, 16'h1234, "R2 after tick");

        // R9 event counting
        run(8'h02);
        pin_pulses(3);
        expect_word(3'd6, 16'd3, "R9 rising edges");
        run(8'h00);
        expect_word(3'd6, 16'd0, "R3 stop clears");
        run(8'h03);
        pin_pulses(2);
        expect_word(3'd6, 16'd2, "R9 falling edges");
        run(8'h00);

        // R4 timer match
        wr(3'd4, 8'h04);
        set_ab(16'd3, 16'hFFFF);
        run(8'h01);
        irq0 = irq_seen;
        ticks(2);
        expect_word(3'd6, 16'd2, "R3 command start");
        ticks(2);
        expect_word(3'd6, 16'd0, "R4 match clears");
        expect_item(2, 3'd0, 16'(irq0 + 1), "R4 one irq");
        // R5 locked configuration
        wr(3'd4, 8'h80);
        expect_item(0, 3'd4, 16'h0004, "R5 cfg ignored");
        expect_item(1, 3'd0, 16'h0000, "R5 pulse_out kept");
        run(8'h00);

        // R13 auto-capture
        run(8'h05);
        ticks(3);
        expect_word(3'd2, 16'd2, "R13 autocap into B");
        run(8'h00);

        // R6 preset
        wr(3'd4, 8'h80);
        expect_item(1, 3'd0, 16'h0001, "R6 preset one");
        wr(3'd4, 8'h07);
        expect_item(1, 3'd0, 16'h0000, "R6 preset zero");

        // R7 continuous pulses
        set_ab(16'd5, 16'd2);
        run(8'h01);
        ticks(3);
        expect_item(1, 3'd0, 16'h0001, "R7 toggle at B");
        ticks(3);
        expect_item(1, 3'd0, 16'h0000, "R7 toggle at A");
        expect_word(3'd6, 16'd0, "R7 clear at A");
        ticks(3);
        expect_item(1, 3'd0, 16'h0001, "R7 continues");
        run(8'h00);

        // R8 one-shot
        wr(3'd4, 8'h27);
        run(8'h01);
        ticks(6);
        ticks(3);
        expect_word(3'd6, 16'd0, "R8 count held");
        expect_item(1, 3'd0, 16'h0000, "R8 pulse ended");
        run(8'h00);

        // R11 external trigger with stop
        wr(3'd4, 8'h14);
        run(8'h02);
        ticks(2);
        expect_word(3'd6, 16'd0, "R11 waits for edge");
        pin_to(1'b1);
        ticks(2);
        expect_word(3'd6, 16'd2, "R11 counts after rise");
        pin_to(1'b0);
        ticks(2);
        expect_word(3'd6, 16'd2, "R11 halted on fall");
        run(8'h00);

        // R10 window
        wr(3'd4, 8'h05);
        run(8'h02);
        pin_to(1'b1);
        ticks(2);
        pin_to(1'b0);
        ticks(3);
        expect_word(3'd6, 16'd2, "R10 gated by pin");
        run(8'h00);

        // R12 single-edge capture
        wr(3'd4, 8'h46);
        run(8'h02);
        irq0 = irq_seen;
        pin_to(1'b1);
        ticks(4);
        pin_to(1'b0);
        expect_word(3'd2, 16'd4, "R12 single capture");
        expect_item(2, 3'd0, 16'(irq0 + 1), "R12 capture irq");
        run(8'h00);

        // R12 double-edge capture
        wr(3'd4, 8'h06);
        run(8'h02);
        pin_to(1'b1);
        ticks(3);
        pin_to(1'b0);
        expect_word(3'd2, 16'd3, "R12 double first");
        ticks(2);
        pin_to(1'b1);
        expect_word(3'd2, 16'd2, "R12 double second");
        run(8'h00);

        finished = 1;
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule